// File: doc/BRIEF.md
# E1 CRC-4 Sub-Multiframe Checker

This block sits behind an E1 receive framer that has already found multiframe phase. It receives the serial bit stream one bit per strobe, together with the current frame number (0 to 15 within the multiframe) and a flag that marks the first bit of timeslot 0, the Si position. Each multiframe is treated as two halves of eight frames. Over each half the block divides the received bits by the CRC-4 generator. It then checks the result against the four check bits carried in the Si positions of the even frames of the half that follows.

A mismatch raises a one-cycle error pulse, together with a flag saying which half's data failed. The block also takes the two far-end block error indicators from the Si positions of frames 13 and 15. A zero in either of them raises a one-cycle count pulse. Whenever the multiframe sync input is low, the checker holds itself idle. After sync returns it waits for one whole half before it compares anything.

Top module: `e1_crc4_smf_checker`

## Requirements
- R1: Over each half (frames 0-7, or frames 8-15) the block forms the remainder of M(x)·x^4 divided by x^4 + x + 1. M(x) is every strobed bit of the half, first bit as the highest power. The Si bit of each even frame counts as 0.
- R2: The Si bits of frames 0, 2, 4, 6 (or 8, 10, 12, 14) form the received check word, the first of them being the most significant bit. It is compared with the remainder of the preceding half. On a mismatch `crc_err` is high for exactly the one cycle after the edge that accepts the last check bit.
- R3: With each error pulse, `crc_err_half` takes 0 if the failing remainder covered frames 0-7 and 1 if it covered frames 8-15. It keeps that value until the next error.
- R4: After sync rises, the first half boundary (Si of frame 0 or 8) starts the first remainder. Only the check bits of the half after that first complete half are compared, so no error is reported before then.
- R5: While `mf_sync` is low there are no pulses, the checker state is cleared, and `ebits` returns to 2'b11. When sync is regained the wait of R4 starts over.
- R6: The Si bit of frame 13 is stored in `ebits[0]` and the Si bit of frame 15 in `ebits[1]`. Each is visible from the cycle after the accepting edge.
- R7: A received E bit of 0 gives a one-cycle `febe` pulse in the cycle after the accepting edge. A 1 gives none.
- R8: Input values in cycles with `bit_valid` low have no effect on any output.
- R9: After reset, `crc_err` = 0, `crc_err_half` = 0, `febe` = 0 and `ebits` = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mf_sync | input | 1 | Multiframe phase is known |
| bit_valid | input | 1 | Bit strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Received serial bit |
| si_pos | input | 1 | Current bit is the first bit of timeslot 0 |
| frame_num | input | 4 | Frame index 0-15 within the multiframe |
| crc_err | output | 1 | One-cycle pulse on a check-word mismatch |
| crc_err_half | output | 1 | Half whose data failed (0 = frames 0-7, 1 = frames 8-15) |
| febe | output | 1 | One-cycle pulse per far-end block error |
| ebits | output | 2 | Last received E bits: [0] from frame 13, [1] from frame 15 |

## Verification
Every output is registered once after the decode of the accepted bit. Error and far-end pulses are therefore due exactly one rising edge after the strobe that carries the last check bit or the E bit, and `ebits` changes at that same edge. The bench drives each strobe just after a falling edge and updates its reference for the next rising edge. It then compares all four outputs at the following falling edge, so each expected pulse is checked in its single cycle and the cycles on either side are checked for no pulse. Pulse counts per multiframe scenario add checks against the known number of injected faults.

// File: rtl/e1c4_pkg.sv
package e1c4_pkg;

    // Remainder width and generator (x^4 + x + 1 without the top term)
    localparam int CRC_W = 4;
    localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

    // Multiframe geometry: two halves, each holding CRC_W check bits in even frames
    localparam int NUM_FRAMES = 16;
    localparam int FN_W       = $clog2(NUM_FRAMES);
    localparam int HALF_FRAMES = NUM_FRAMES / 2;
    localparam int CIDX_W     = $clog2(CRC_W);

    // Far-end indicator frames: E_BASE, E_BASE + E_STEP, ...
    localparam int NUM_E   = 2;
    localparam int E_BASE  = 13;
    localparam int E_STEP  = 2;
    localparam int EIDX_W  = (NUM_E > 1) ? $clog2(NUM_E) : 1;

    typedef enum logic [1:0] {
        ARM_IDLE  = 2'd0,
        ARM_FIRST = 2'd1,
        ARM_READY = 2'd2
    } arm_state_e;

    // One step of the division register, bit entering at the top
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic             din);
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    endfunction

endpackage

// File: rtl/e1c4_slot_decode.sv
module e1c4_slot_decode
    import e1c4_pkg::*;
(
    input  logic              mf_sync,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              si_pos,
    input  logic [FN_W-1:0]   frame_num,
    output logic              acc,
    output logic              din,
    output logic              crc_din,
    output logic              half_start,
    output logic              cur_half,
    output logic              is_c,
    output logic [CIDX_W-1:0] c_idx,
    output logic              is_e,
    output logic [EIDX_W-1:0] e_idx
);
    logic              is_si;
    logic [FN_W-2:0]   fn_in_half;
    logic [NUM_E-1:0]  e_hit;

    assign acc        = bit_valid & mf_sync;
    assign din        = bit_in;
    assign is_si      = acc & si_pos;
    assign fn_in_half = frame_num[FN_W-2:0];
    assign cur_half   = frame_num[FN_W-1];
    assign half_start = is_si && (fn_in_half == '0);

    // Check bits live in the Si slot of every even frame of a half
    assign is_c    = is_si && !frame_num[0];
    assign c_idx   = fn_in_half[CIDX_W:1];
    assign crc_din = is_c ? 1'b0 : bit_in;

    for (genvar gi = 0; gi < NUM_E; gi++) begin : g_ehit
        assign e_hit[gi] = is_si && (frame_num == FN_W'(E_BASE + E_STEP * gi));
    end

    assign is_e = |e_hit;

    always_comb begin
        e_idx = '0;
        for (int i = 0; i < NUM_E; i++) begin
            if (e_hit[i]) e_idx = EIDX_W'(i);
        end
    end

endmodule

// File: rtl/e1c4_crc_engine.sv
module e1c4_crc_engine
    import e1c4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mf_sync,
    input  logic             acc,
    input  logic             crc_din,
    input  logic             half_start,
    input  logic             cur_half,
    output logic [CRC_W-1:0] exp_crc,
    output logic             exp_half,
    output logic             exp_vld
);
    arm_state_e       state;
    logic [CRC_W-1:0] crc;

    always_ff @(posedge clk) begin
        if (rst || !mf_sync) begin
            state    <= ARM_IDLE;
            crc      <= '0;
            exp_crc  <= '0;
            exp_half <= 1'b0;
        end else if (acc) begin
            if (half_start) begin
                crc <= crc_step('0, crc_din);
                if (state != ARM_IDLE) begin
                    exp_crc  <= crc;
                    exp_half <= ~cur_half;
                    state    <= ARM_READY;
                end else begin
                    state <= ARM_FIRST;
                end
            end else if (state != ARM_IDLE) begin
                crc <= crc_step(crc, crc_din);
            end
        end
    end

    assign exp_vld = (state == ARM_READY);

    AST_IDLE_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
        !mf_sync |=> !exp_vld);  // R5

    AST_ARM_AFTER_FULL_HALF: assert property (@(posedge clk) disable iff (rst)
        $rose(exp_vld) |-> $past(state == ARM_FIRST && half_start && acc));  // R4

endmodule

// File: rtl/e1c4_check_compare.sv
module e1c4_check_compare
    import e1c4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              is_c,
    input  logic [CIDX_W-1:0] c_idx,
    input  logic [CRC_W-1:0]  exp_crc,
    input  logic              exp_half,
    input  logic              exp_vld,
    output logic              crc_err,
    output logic              crc_err_half
);
    logic [CRC_W-1:0] rx_c;
    logic [CRC_W-1:0] rx_next;
    logic             last_c;

    // First check bit of a half is the most significant
    always_comb begin
        rx_next = rx_c;
        for (int i = 0; i < CRC_W; i++) begin
            if (c_idx == CIDX_W'(i)) rx_next[CRC_W-1-i] = din;
        end
    end

    assign last_c = (c_idx == CIDX_W'(CRC_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_c         <= '0;
            crc_err      <= 1'b0;
            crc_err_half <= 1'b0;
        end else begin
            crc_err <= 1'b0;
            if (is_c) begin
                rx_c <= rx_next;
                if (last_c && exp_vld && (rx_next != exp_crc)) begin
                    crc_err      <= 1'b1;
                    crc_err_half <= exp_half;
                end
            end
        end
    end

    AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> !crc_err);  // R2

    AST_ERR_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> $past(exp_vld && is_c));  // R4

    AST_TAG_MOVES_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
        (crc_err_half != $past(crc_err_half)) |-> crc_err);  // R3

endmodule

// File: rtl/e1c4_ebit_extract.sv
module e1c4_ebit_extract
    import e1c4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mf_sync,
    input  logic              din,
    input  logic              is_e,
    input  logic [EIDX_W-1:0] e_idx,
    output logic              febe,
    output logic [NUM_E-1:0]  ebits
);
    always_ff @(posedge clk) begin
        if (rst || !mf_sync) begin
            febe  <= 1'b0;
            ebits <= '1;
        end else begin
            febe <= is_e && !din;
            if (is_e) ebits[e_idx] <= din;
        end
    end

    AST_FEBE_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        febe |-> $past(is_e && !din));  // R7

    AST_EBITS_IDLE_UNSYNC: assert property (@(posedge clk) disable iff (rst)
        !mf_sync |=> (ebits == '1 && !febe));  // R5

endmodule

// File: rtl/e1_crc4_smf_checker.sv
module e1_crc4_smf_checker
    import e1c4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mf_sync,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             si_pos,
    input  logic [FN_W-1:0]  frame_num,
    output logic             crc_err,
    output logic             crc_err_half,
    output logic             febe,
    output logic [NUM_E-1:0] ebits
);
    logic              acc;
    logic              din;
    logic              crc_din;
    logic              half_start;
    logic              cur_half;
    logic              is_c;
    logic [CIDX_W-1:0] c_idx;
    logic              is_e;
    logic [EIDX_W-1:0] e_idx;
    logic [CRC_W-1:0]  exp_crc;
    logic              exp_half;
    logic              exp_vld;

    e1c4_slot_decode u_decode (
        .mf_sync    (mf_sync),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .si_pos     (si_pos),
        .frame_num  (frame_num),
        .acc        (acc),
        .din        (din),
        .crc_din    (crc_din),
        .half_start (half_start),
        .cur_half   (cur_half),
        .is_c       (is_c),
        .c_idx      (c_idx),
        .is_e       (is_e),
        .e_idx      (e_idx)
    );

    e1c4_crc_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .mf_sync    (mf_sync),
        .acc        (acc),
        .crc_din    (crc_din),
        .half_start (half_start),
        .cur_half   (cur_half),
        .exp_crc    (exp_crc),
        .exp_half   (exp_half),
        .exp_vld    (exp_vld)
    );

    e1c4_check_compare u_compare (
        .clk          (clk),
        .rst          (rst),
        .din          (din),
        .is_c         (is_c),
        .c_idx        (c_idx),
        .exp_crc      (exp_crc),
        .exp_half     (exp_half),
        .exp_vld      (exp_vld),
        .crc_err      (crc_err),
        .crc_err_half (crc_err_half)
    );

    e1c4_ebit_extract u_ebits (
        .clk     (clk),
        .rst     (rst),
        .mf_sync (mf_sync),
        .din     (din),
        .is_e    (is_e),
        .e_idx   (e_idx),
        .febe    (febe),
        .ebits   (ebits)
    );

endmodule

// File: tb/e1_crc4_smf_checker_tb.sv
`timescale 1ns/1ps
module e1_crc4_smf_checker_tb;

    localparam int FR_BITS = 256;

    logic       clk = 1'b0;
    logic       rst;
    logic       mf_sync;
    logic       bit_valid;
    logic       bit_in;
    logic       si_pos;
    logic [3:0] frame_num;
    logic       crc_err;
    logic       crc_err_half;
    logic       febe;
    logic [1:0] ebits;

    always #2.5 clk = ~clk;

    e1_crc4_smf_checker u_dut (
        .clk          (clk),
        .rst          (rst),
        .mf_sync      (mf_sync),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .si_pos       (si_pos),
        .frame_num    (frame_num),
        .crc_err      (crc_err),
        .crc_err_half (crc_err_half),
        .febe         (febe),
        .ebits        (ebits)
    );

    int n_vec  = 0;
    int n_fail = 0;
    int n_err_seen  = 0;
    int n_febe_seen = 0;
    bit finished = 0;

    // reference model state
    logic       drv_sync = 1'b0;
    int         m_phase  = 0;
    bit         m_q[$];
    logic [3:0] m_crc = 4'h0;
    logic       m_half = 1'b0;
    logic [3:0] m_rx = 4'h0;
    logic       x_err = 1'b0, x_half = 1'b0, x_febe = 1'b0;
    logic [1:0] x_e = 2'b11;

    // transmitter state
    bit         tx_q[$];
    logic [3:0] tx_prev = 4'h0;
    logic [3:0] cur_mask = 4'h0;
    logic       tx_e1 = 1'b1, tx_e2 = 1'b1;

    // Long division of M(x)*x^4 by x^4+x+1
    function automatic logic [3:0] crc_of(input bit q[$]);
        logic [4:0] r;
        r = 5'b0;
        foreach (q[i]) begin
            r = {r[3:0], q[i]};
            if (r[4]) r = r ^ 5'b10011;
        end
        for (int k = 0; k < 4; k++) begin
            r = {r[3:0], 1'b0};
            if (r[4]) r = r ^ 5'b10011;
        end
        return r[3:0];
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic compare_now();
        n_vec++;
        if (crc_err !== x_err) begin
            n_fail++;
            $display("FAIL R2 crc_err at %0t: actual %b expected %b", $time, crc_err, x_err);
        end
        if (crc_err_half !== x_half) begin
            n_fail++;
            $display("FAIL R3 crc_err_half at %0t: actual %b expected %b", $time, crc_err_half, x_half);
        end
        if (febe !== x_febe) begin
            n_fail++;
            $display("FAIL R7 febe at %0t: actual %b expected %b", $time, febe, x_febe);
        end
        if (ebits !== x_e) begin
            n_fail++;
            $display("FAIL R6 ebits at %0t: actual %b expected %b", $time, ebits, x_e);
        end
        if (crc_err === 1'b1) n_err_seen++;
        if (febe === 1'b1) n_febe_seen++;
    endtask

    // Predict the outputs after the coming rising edge
    task automatic model(input logic v, input logic b, input logic si, input logic [3:0] fn);
        x_err  = 1'b0;
        x_febe = 1'b0;
        if (!drv_sync) begin
            m_phase = 0;
            m_q.delete();
            x_e = 2'b11;
        end else if (v) begin
            if (si && fn[2:0] == 3'd0) begin
                if (m_phase != 0) begin
                    m_crc   = crc_of(m_q);
                    m_half  = ~fn[3];
                    m_phase = 2;
                end else begin
                    m_phase = 1;
                end
                m_q.delete();
            end
            if (m_phase != 0) m_q.push_back((si && !fn[0]) ? 1'b0 : b);
            if (si && !fn[0]) begin
                m_rx[3 - fn[2:1]] = b;
                if (fn[2:1] == 2'd3 && m_phase == 2 && m_rx != m_crc) begin
                    x_err  = 1'b1;
                    x_half = m_half;
                end
            end
            if (si && fn == 4'd13) begin x_e[0] = b; x_febe = !b; end
            if (si && fn == 4'd15) begin x_e[1] = b; x_febe = !b; end
        end
    endtask

    task automatic step(input logic v, input logic b, input logic si, input logic [3:0] fn);
        @(negedge clk);
        compare_now();
        mf_sync   = drv_sync;
        bit_valid = v;
        bit_in    = b;
        si_pos    = si;
        frame_num = fn;
        model(v, b, si, fn);
    endtask

    task automatic send_frame(input logic [3:0] fn);
        logic b;
        for (int k = 0; k < FR_BITS; k++) begin
            if (k == 0) begin
                if (!fn[0])         b = tx_prev[3 - fn[2:1]] ^ cur_mask[3 - fn[2:1]];
                else if (fn == 13)  b = tx_e1;
                else if (fn == 15)  b = tx_e2;
                else                b = 1'((6'b001011 >> (5 - (fn - 1) / 2)) & 1);
            end else begin
                b = 1'($urandom);
            end
            tx_q.push_back((k == 0 && !fn[0]) ? 1'b0 : b);
            // idle strobe cycles carry garbage that must be ignored (R8)
            if ($urandom % 4 == 0) step(1'b0, 1'($urandom), 1'($urandom), fn);
            step(1'b1, b, (k == 0), fn);
        end
    endtask

    task automatic send_mf(input logic [3:0] mask_a, input logic [3:0] mask_b,
                           input logic e1v, input logic e2v,
                           input int sync_on, input int sync_off);
        tx_e1 = e1v;
        tx_e2 = e2v;
        for (int fn = 0; fn < 16; fn++) begin
            if (fn == sync_on)  drv_sync = 1'b1;
            if (fn == sync_off) drv_sync = 1'b0;
            if (fn % 8 == 0) begin
                if (tx_q.size() != 0) tx_prev = crc_of(tx_q);
                tx_q.delete();
            end
            cur_mask = (fn < 8) ? mask_a : mask_b;
            send_frame(4'(fn));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int e0, f0;
        rst = 1'b1; mf_sync = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        si_pos = 1'b0; frame_num = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset values
        chk(crc_err == 1'b0 && febe == 1'b0, "R9 reset pulses", int'({crc_err, febe}), 0);
        chk(crc_err_half == 1'b0, "R9 reset crc_err_half", int'(crc_err_half), 0);
        chk(ebits == 2'b11, "R9 reset ebits", int'(ebits), 3);
        rst = 1'b0;

        // Unsynced: corrupt check bits and zero E bits are ignored (R5)
        e0 = n_err_seen; f0 = n_febe_seen;
        send_mf(4'b1111, 4'b0101, 1'b0, 1'b0, -1, -1);
        chk(n_err_seen == e0, "R5 no error while unsynced", n_err_seen - e0, 0);
        chk(n_febe_seen == f0, "R5 no febe while unsynced", n_febe_seen - f0, 0);

        // Sync at frame 3: first boundary at frame 8, its check bits not compared (R4)
        e0 = n_err_seen;
        send_mf(4'b0000, 4'b1001, 1'b1, 1'b1, 3, -1);
        send_mf(4'b0000, 4'b0000, 1'b1, 1'b1, -1, -1);
        chk(n_err_seen == e0, "R4 no check before a full half", n_err_seen - e0, 0);

        // Clean traffic with idle strobes: no errors (R1, R8)
        e0 = n_err_seen;
        repeat (3) send_mf(4'b0000, 4'b0000, 1'b1, 1'b1, -1, -1);
        chk(n_err_seen == e0, "R1 correct remainders accepted", n_err_seen - e0, 0);
        chk(n_febe_seen == f0, "R8 idle-strobe garbage ignored", n_febe_seen - f0, 0);

        // Bad check bit in frames 0-6: failing data is frames 8-15 (R2, R3)
        e0 = n_err_seen;
        send_mf(4'b0100, 4'b0000, 1'b1, 1'b1, -1, -1);
        chk(n_err_seen == e0 + 1, "R2 single error for bad first-half word", n_err_seen - e0, 1);
        chk(crc_err_half == 1'b1, "R3 tag for frames 8-15 data", int'(crc_err_half), 1);
        e0 = n_err_seen;
        send_mf(4'b0000, 4'b0001, 1'b1, 1'b1, -1, -1);
        chk(n_err_seen == e0 + 1, "R2 single error for bad LSB in second half", n_err_seen - e0, 1);
        chk(crc_err_half == 1'b0, "R3 tag for frames 0-7 data", int'(crc_err_half), 0);

        // E bits (R6, R7)
        f0 = n_febe_seen;
        send_mf(4'b0000, 4'b0000, 1'b0, 1'b1, -1, -1);
        chk(ebits == 2'b10, "R6 ebits after E1=0 E2=1", int'(ebits), 2);
        send_mf(4'b0000, 4'b0000, 1'b1, 1'b0, -1, -1);
        chk(ebits == 2'b01, "R6 ebits after E1=1 E2=0", int'(ebits), 1);
        send_mf(4'b0000, 4'b0000, 1'b0, 1'b0, -1, -1);
        chk(n_febe_seen == f0 + 4, "R7 febe count", n_febe_seen - f0, 4);

        // Loss of sync at frame 10 (R5)
        f0 = n_febe_seen;
        send_mf(4'b0000, 4'b0000, 1'b0, 1'b0, -1, 10);
        chk(ebits == 2'b11, "R5 ebits cleared on loss of sync", int'(ebits), 3);
        chk(n_febe_seen == f0, "R5 no febe after loss of sync", n_febe_seen - f0, 0);

        // Resync restarts the wait, then checking resumes (R5, R4)
        e0 = n_err_seen;
        send_mf(4'b1111, 4'b1111, 1'b1, 1'b1, 3, -1);
        chk(n_err_seen == e0, "R5 wait restarts after resync", n_err_seen - e0, 0);
        send_mf(4'b1000, 4'b0000, 1'b1, 1'b1, -1, -1);
        chk(n_err_seen == e0 + 1, "R2 checking resumes after resync", n_err_seen - e0, 1);
        chk(crc_err_half == 1'b1, "R3 tag after resync", int'(crc_err_half), 1);

        step(1'b0, 1'b0, 1'b0, 4'd0);
        step(1'b0, 1'b0, 1'b0, 4'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule